// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block makes the count-enable strobe for one general-purpose timer. It picks one of four free-running sources. Three are internal: the system clock divided by 12, the system clock divided by 4, and a separate divide-by-13. The fourth is an external count pin, which is synchronized and reduced to one event per falling edge. Each selected event appears on `count_en` as a pulse exactly one system clock wide. The timer register next to the block advances on each of these pulses.

Three static control bits pick the source:

- `ct_sel` chooses between timer use (internal divider) and counter use (pin or divide-by-13).
- `speed_sel` chooses the fast or the slow divider.
- `alt_div_en` asks for the divide-by-13 source. It only has an effect while `ct_sel` is 1, and then it overrides `speed_sel`.

A chip places one instance per timer. The controls are plain level inputs. The only output is a single strobe, so there is no stream interface and no back-pressure: a pulse that the timer does not use is simply gone.

Top module: `timer_clk_sel`

## Requirements
- R1: While `rst_n` is low, `count_en` is 0, and all dividers and the pin synchronizer are held cleared.
- R2: With `ct_sel`=0, `speed_sel`=0 and `alt_div_en`=0, `count_en` pulses once every 12 clocks.
- R3: With `ct_sel`=0 and `speed_sel`=1, `count_en` pulses once every 4 clocks.
- R4: With `ct_sel`=1 and `alt_div_en`=1, `count_en` pulses once every 13 clocks. This holds for either value of `speed_sel`.
- R5: While `ct_sel`=0, `alt_div_en` has no effect, and the period is set by `speed_sel` alone (12 or 4).
- R6: With `ct_sel`=1 and `alt_div_en`=0, each falling edge of `ext_pin` produces exactly one pulse. The pin must be stable across the edge before its first sampling clock. The pulse is high after the 4th rising clock edge that follows the fall: two synchronizer stages, one edge-detect register and the output register. A rising edge produces no pulse, and neither does a static pin level.
- R7: `count_en` is never high for more than one clock. It is never high in two adjacent clocks, even while the selection is changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the clock that all dividers divide |
| rst_n | input | 1 | Active-low synchronous reset |
| ct_sel | input | 1 | 0: internal divider (timer use); 1: pin or divide-by-13 (counter use) |
| speed_sel | input | 1 | 0: divide by 12; 1: divide by 4 (used only when `ct_sel`=0) |
| alt_div_en | input | 1 | 1 with `ct_sel`=1 selects the divide-by-13 source |
| ext_pin | input | 1 | Asynchronous external count input |
| count_en | output | 1 | One-clock count-enable strobe |

## Verification
A divider whose count is wrong shows up at once as a period that is not 12, 4 or 13 clocks. The distance between two successive pulses therefore exposes it within one period of the selected source. A wrong source decode shows the period of a different source within the same span. A fault in the synchronizer or the edge detector shows up within four clocks of a pin edge: the pulse comes at a different latency, comes on the rising edge, or comes twice. A broken lockout on the output register shows as two adjacent high cycles the first time the selection is switched between sources that are pulsing.

// File: rtl/tck_pkg.sv
package tck_pkg;
  // Source chosen for the count-enable strobe
  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_FAST = 2'd1,
    SRC_ALT  = 2'd2,
    SRC_PIN  = 2'd3
  } src_t;

  localparam int NUM_SRC = 4;
  localparam int NUM_DIV = 3;
endpackage

// File: rtl/tck_prescaler.sv
module tck_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // tick follows the wrap, so the counter is back at zero whenever it is high
  AST_TICK_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt == '0)); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R7
endmodule

// File: rtl/tck_edge_sync.sv
module tck_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  // s[STAGES-1] is the synchronized level, s[STAGES] its previous value
  logic [STAGES:0] s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s    <= '0;
      fall <= 1'b0;
    end else begin
      s    <= {s[STAGES-1:0], pin};
      fall <= s[STAGES] & ~s[STAGES-1];
    end
  end

  AST_FALL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (s[STAGES] && !s[STAGES-1]) |=> fall); // R6
  AST_FALL_NOT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> !s[STAGES]); // R6
endmodule

// File: rtl/tck_src_mux.sv
module tck_src_mux
  import tck_pkg::*;
(
  input  logic               ct_sel,
  input  logic               speed_sel,
  input  logic               alt_div_en,
  input  logic [NUM_SRC-1:0] pulses,
  output src_t               src,
  output logic               sel_pulse
);
  always_comb begin
    if (ct_sel) begin
      src = alt_div_en ? SRC_ALT : SRC_PIN;
    end else begin
      src = speed_sel ? SRC_FAST : SRC_SLOW;
    end
    sel_pulse = pulses[src];
  end
endmodule

// File: rtl/timer_clk_sel.sv
module timer_clk_sel
  import tck_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int DIV_ALT     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ct_sel,
  input  logic speed_sel,
  input  logic alt_div_en,
  input  logic ext_pin,
  output logic count_en
);
  function automatic int div_of(input int idx);
    case (idx)
      0:       return DIV_SLOW;
      1:       return DIV_FAST;
      default: return DIV_ALT;
    endcase
  endfunction

  logic [NUM_SRC-1:0] pulses;
  src_t               src;
  logic               sel_pulse;

  // One free-running divider per internal source, index equal to src_t code
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    tck_prescaler #(.DIV(div_of(i))) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (pulses[i])
    );
  end

  tck_edge_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_pin),
    .fall (pulses[SRC_PIN])
  );

  tck_src_mux u_mux (
    .ct_sel    (ct_sel),
    .speed_sel (speed_sel),
    .alt_div_en(alt_div_en),
    .pulses    (pulses),
    .src       (src),
    .sel_pulse (sel_pulse)
  );

  // Output register with a one-cycle lockout: a source switch cannot merge two strobes
  always_ff @(posedge clk) begin
    if (!rst_n) count_en <= 1'b0;
    else        count_en <= sel_pulse & ~count_en;
  end

  AST_EN_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |=> !count_en); // R7
  AST_EN_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> $past(sel_pulse)); // R6
  AST_ALT_NEEDS_CT: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_ALT) |-> (ct_sel && alt_div_en)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !count_en); // R1
endmodule

// File: tb/tb_timer_clk_sel.sv
`timescale 1ns/1ps
module tb_timer_clk_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ct_sel = 1'b0, speed_sel = 1'b0, alt_div_en = 1'b0, ext_pin = 1'b1;
  logic count_en;

  int checks = 0;
  int fails  = 0;
  int adjacent = 0;
  logic prev_en = 1'b0;

  always #2.5 clk = ~clk;

  timer_clk_sel dut (
    .clk(clk), .rst_n(rst_n), .ct_sel(ct_sel), .speed_sel(speed_sel),
    .alt_div_en(alt_div_en), .ext_pin(ext_pin), .count_en(count_en)
  );

  // Adjacent-pulse monitor for R7
  always @(negedge clk) begin
    if (rst_n && count_en && prev_en) adjacent++;
    prev_en = count_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic ct, input logic sp, input logic alt);
    @(negedge clk);
    ct_sel = ct; speed_sel = sp; alt_div_en = alt;
    repeat (30) @(negedge clk);
  endtask

  task automatic window(input int n, output int cnt, output int gmin, output int gmax);
    int last = -1;
    cnt = 0; gmin = 1 << 30; gmax = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (count_en) begin
        cnt++;
        if (last >= 0) begin
          if (i - last < gmin) gmin = i - last;
          if (i - last > gmax) gmax = i - last;
        end
        last = i;
      end
    end
  endtask

  task automatic period_test(input string req, input int div);
    int c, lo, hi;
    window(156, c, lo, hi);
    chk(c == 156 / div, req, c, 156 / div);
    chk(lo == div && hi == div, req, hi, div);
  endtask

  task automatic test_reset();
    int hits = 0;
    rst_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (count_en) hits++;
    end
    chk(hits == 0, "R1 quiet in reset", hits, 0);
    rst_n = 1'b1;
    window(12, hits, hits, hits);
    chk(!count_en, "R1 no early strobe", count_en, 0);
  endtask

  task automatic test_timer();
    set_mode(1'b0, 1'b0, 1'b0); period_test("R2 divide by 12", 12);
    set_mode(1'b0, 1'b1, 1'b0); period_test("R3 divide by 4", 4);
    set_mode(1'b0, 1'b0, 1'b1); period_test("R5 alt ignored slow", 12);
    set_mode(1'b0, 1'b1, 1'b1); period_test("R5 alt ignored fast", 4);
  endtask

  task automatic test_alt();
    set_mode(1'b1, 1'b0, 1'b1); period_test("R4 divide by 13", 13);
    set_mode(1'b1, 1'b1, 1'b1); period_test("R4 speed ignored", 13);
  endtask

  task automatic test_pin();
    int c, lo, hi;
    set_mode(1'b1, 1'b0, 1'b0);
    ext_pin = 1'b0;
    c = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (count_en) c++;
    end
    chk(c == 0, "R6 no early pulse", c, 0);
    @(negedge clk);
    chk(count_en == 1'b1, "R6 latency 4", count_en, 1);
    @(negedge clk);
    ext_pin = 1'b1;
    window(10, c, lo, hi);
    chk(c == 0, "R6 rise ignored", c, 0);
    window(50, c, lo, hi);
    chk(c == 0, "R6 static pin", c, 0);
    fork
      begin
        for (int k = 0; k < 10; k++) begin
          ext_pin = 1'b0; repeat (4) @(negedge clk);
          ext_pin = 1'b1; repeat (4) @(negedge clk);
        end
      end
      window(90, c, lo, hi);
    join
    chk(c == 10, "R6 one pulse per fall", c, 10);
    chk(lo == 8 && hi == 8, "R6 pulse spacing", hi, 8);
  endtask

  task automatic test_switching();
    int start = adjacent;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      ct_sel = k[0]; speed_sel = k[1]; alt_div_en = k[2] ^ k[0];
      ext_pin = k[1];
    end
    set_mode(1'b0, 1'b1, 1'b0);
    chk(adjacent == start, "R7 no adjacent strobes", adjacent - start, 0);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_timer();
        test_alt();
        test_pin();
        test_switching();
        chk(adjacent == 0, "R7 one clock wide overall", adjacent, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 1, 0);
      end
    join_any
    disable fork;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule